// File: doc/BRIEF.md
# Selectable Arithmetic Unit

This block is a purely combinational arithmetic stage. It takes two unsigned operands and a two-bit function code, and drives one result bus of twice the operand width. The function code picks one of three jobs: add, multiply or compare. A fourth code parks the bus at zero. The unit has no clock and no state, so the result tracks the inputs after the logic settles.

Every arithmetic path is built from explicit gates. The adder is a chain of four-bit carry-lookahead groups. The multiplier is a parallel array of AND partial products, and each row is summed by one such adder chain. The comparator makes its decision with a most-significant-first equality chain. A zero-padding multiplexer places each function's result on the common bus.

Top module: `sel_arith_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `result[8:0]` holds the 9-bit sum `opnd_a + opnd_b`, with the carry-out in bit 8. Bits 15:9 are zero.
- R2: With `op_sel` = 2'b01 (multiply), `result[15:0]` holds the full unsigned 16-bit product `opnd_a * opnd_b`.
- R3: With `op_sel` = 2'b10 (compare), `result[2]` is set when a > b, `result[1]` is set when a == b and `result[0]` is set when a < b. Exactly one of these three bits is set, and bits 15:3 are zero.
- R4: With `op_sel` = 2'b11, `result` is all zeros for any operand values.
- R5: The output has no memory. When only `op_sel` changes while the operands are held, `result` shows the newly selected function in the same cycle.
- R6: Extreme operands give exact results: 255+255 = 0x01FE, 255*255 = 0xFE01, any operand times zero is 0, and equal operands (including 0 and 255) compare as equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First unsigned operand |
| opnd_b | input | 8 | Second unsigned operand |
| op_sel | input | 2 | Function code: 00 add, 01 multiply, 10 compare, 11 zero |
| result | output | 16 | Zero-padded result of the selected function |

## Verification
The assertions run on every input change and check the following:
- the three comparator flags are one-hot, and the equal flag agrees with operand equality;
- the adder passes an operand through unchanged when the other operand is zero;
- the multiplier returns the first operand when the second is one;
- the padding bits above each function's field stay zero.

Only the bench's scenarios can show full numeric correctness. For that it walks a strided sweep of operand pairs against reference arithmetic, plus a table of extreme values. It also switches the function code under fixed operands to show that the result follows the selection with no hidden state.

// File: rtl/sau_pkg.sv
`timescale 1ns/1ps
package sau_pkg;
  localparam int unsigned OPND_W  = 8;
  localparam int unsigned RES_W   = 2 * OPND_W;
  localparam int unsigned GROUP_W = 4;

  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_MUL  = 2'b01,
    FN_CMP  = 2'b10,
    FN_ZERO = 2'b11
  } fn_code_t;
endpackage

// File: rtl/cla_group4.sv
`timescale 1ns/1ps
module cla_group4 (
  input  logic [3:0] x,
  input  logic [3:0] y,
  input  logic       c_in,
  output logic [3:0] sum,
  output logic       c_out
);
  logic [3:0] prop;
  logic [3:0] gen;
  logic [4:0] cy;

  for (genvar k = 0; k < 4; k++) begin : g_bit
    assign prop[k] = x[k] ^ y[k];
    assign gen[k]  = x[k] & y[k];
    assign sum[k]  = prop[k] ^ cy[k];
  end

  // Two-level lookahead: every carry comes straight from c_in, prop and gen
  assign cy[0] = c_in;
  assign cy[1] = gen[0] | (prop[0] & c_in);
  assign cy[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & c_in);
  assign cy[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
               | (prop[2] & prop[1] & prop[0] & c_in);
  assign cy[4] = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
               | (prop[3] & prop[2] & prop[1] & gen[0])
               | (prop[3] & prop[2] & prop[1] & prop[0] & c_in);
  assign c_out = cy[4];
endmodule

// File: rtl/cla_chain.sv
`timescale 1ns/1ps
module cla_chain #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out
);
  localparam int unsigned NGRP = W / sau_pkg::GROUP_W;

  logic [NGRP:0] link;
  assign link[0] = c_in;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    cla_group4 u_grp (
      .x    (x[gi*4 +: 4]),
      .y    (y[gi*4 +: 4]),
      .c_in (link[gi]),
      .sum  (sum[gi*4 +: 4]),
      .c_out(link[gi+1])
    );
  end
  assign c_out = link[NGRP];

  always_comb begin
    if (y == '0 && c_in == 1'b0) begin
      AST_ADD_IDENTITY: assert (sum == x && c_out == 1'b0) // R1
        else $error("adder identity broken");
    end
  end
endmodule

// File: rtl/array_mult.sv
`timescale 1ns/1ps
module array_mult #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] pp   [W];
  logic [W-1:0] row  [W];
  logic         rcy  [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    for (genvar j = 0; j < W; j++) begin : g_and
      assign pp[i][j] = mcand[j] & mplier[i];
    end
  end

  assign row[0]  = pp[0];
  assign rcy[0]  = 1'b0;
  assign prod[0] = row[0][0];

  for (genvar i = 1; i < W; i++) begin : g_row
    cla_chain #(.W(W)) u_row (
      .x    ({rcy[i-1], row[i-1][W-1:1]}),
      .y    (pp[i]),
      .c_in (1'b0),
      .sum  (row[i]),
      .c_out(rcy[i])
    );
    assign prod[i] = row[i][0];
  end

  assign prod[2*W-1:W] = {rcy[W-1], row[W-1][W-1:1]};

  always_comb begin
    if (mplier == W'(1)) begin
      AST_MUL_UNIT: assert (prod == {{W{1'b0}}, mcand}) // R2
        else $error("multiply by one broken");
    end
    if (mplier == '0 || mcand == '0) begin
      AST_MUL_ZERO: assert (prod == '0) // R6
        else $error("multiply by zero broken");
    end
  end
endmodule

// File: rtl/mag_compare.sv
`timescale 1ns/1ps
module mag_compare #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         x_gt,
  output logic         x_eq,
  output logic         x_lt
);
  logic [W:0]   same_above;
  logic [W-1:0] gt_at;
  logic [W-1:0] lt_at;

  assign same_above[W] = 1'b1;
  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign same_above[i] = same_above[i+1] & ~(x[i] ^ y[i]);
    assign gt_at[i]      = same_above[i+1] & x[i] & ~y[i];
    assign lt_at[i]      = same_above[i+1] & ~x[i] & y[i];
  end

  assign x_gt = |gt_at;
  assign x_lt = |lt_at;
  assign x_eq = same_above[0];

  always_comb begin
    AST_CMP_ONEHOT: assert ($countones({x_gt, x_eq, x_lt}) == 1) // R3
      else $error("compare flags not one-hot");
    AST_CMP_EQUAL: assert (x_eq == (x == y)) // R6
      else $error("equal flag wrong");
  end
endmodule

// File: rtl/sel_arith_unit.sv
`timescale 1ns/1ps
module sel_arith_unit
  import sau_pkg::*;
(
  input  logic [OPND_W-1:0] opnd_a,
  input  logic [OPND_W-1:0] opnd_b,
  input  logic [1:0]        op_sel,
  output logic [RES_W-1:0]  result
);
  localparam int unsigned PAD_ADD = RES_W - OPND_W - 1;
  localparam int unsigned PAD_CMP = RES_W - 3;

  logic [OPND_W-1:0] add_sum;
  logic              add_cy;
  logic [RES_W-1:0]  mul_prod;
  logic              c_gt, c_eq, c_lt;
  fn_code_t          fn;

  assign fn = fn_code_t'(op_sel);

  cla_chain #(.W(OPND_W)) u_add (
    .x    (opnd_a),
    .y    (opnd_b),
    .c_in (1'b0),
    .sum  (add_sum),
    .c_out(add_cy)
  );

  array_mult #(.W(OPND_W)) u_mul (
    .mcand (opnd_a),
    .mplier(opnd_b),
    .prod  (mul_prod)
  );

  mag_compare #(.W(OPND_W)) u_cmp (
    .x   (opnd_a),
    .y   (opnd_b),
    .x_gt(c_gt),
    .x_eq(c_eq),
    .x_lt(c_lt)
  );

  always_comb begin
    unique case (fn)
      FN_ADD:  result = {{PAD_ADD{1'b0}}, add_cy, add_sum};
      FN_MUL:  result = mul_prod;
      FN_CMP:  result = {{PAD_CMP{1'b0}}, c_gt, c_eq, c_lt};
      default: result = '0;
    endcase
  end

  always_comb begin
    if (fn == FN_ADD) begin
      AST_ADD_PAD: assert (result[RES_W-1:OPND_W+1] == '0) // R1
        else $error("add padding not zero");
    end
    if (fn == FN_CMP) begin
      AST_CMP_PAD: assert (result[RES_W-1:3] == '0 && $countones(result) == 1) // R3
        else $error("compare field malformed");
    end
    if (fn == FN_ZERO) begin
      AST_IDLE_ZERO: assert (result == '0) // R4
        else $error("idle code not zero");
    end
  end
endmodule

// File: tb/sim_sel_arith_unit.sv
`timescale 1ns/1ps
module sim_sel_arith_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [1:0]  sel = 2'b11;
  logic [15:0] res;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  sel_arith_unit u0 (.opnd_a(a), .opnd_b(b), .op_sel(sel), .result(res));

  // {op, a, b, expected}
  localparam logic [33:0] TBL [17] = '{
    {2'd0, 8'd0,   8'd0,   16'h0000},
    {2'd0, 8'd255, 8'd255, 16'h01FE},
    {2'd0, 8'd255, 8'd1,   16'h0100},
    {2'd0, 8'h0F,  8'h01,  16'h0010},
    {2'd0, 8'h5A,  8'hA5,  16'h00FF},
    {2'd1, 8'd255, 8'd255, 16'hFE01},
    {2'd1, 8'd0,   8'd200, 16'h0000},
    {2'd1, 8'd16,  8'd16,  16'h0100},
    {2'd1, 8'd13,  8'd11,  16'h008F},
    {2'd1, 8'd1,   8'hAB,  16'h00AB},
    {2'd2, 8'd5,   8'd5,   16'h0002},
    {2'd2, 8'd200, 8'd3,   16'h0004},
    {2'd2, 8'd3,   8'd200, 16'h0001},
    {2'd2, 8'd0,   8'd0,   16'h0002},
    {2'd2, 8'd255, 8'd254, 16'h0004},
    {2'd3, 8'd255, 8'd255, 16'h0000},
    {2'd3, 8'd17,  8'd34,  16'h0000}
  };

  function automatic logic [15:0] model(logic [1:0] op, logic [7:0] x, logic [7:0] y);
    logic [8:0] s;
    s = {1'b0, x} + {1'b0, y};
    case (op)
      2'd0:    return {7'd0, s};
      2'd1:    return 16'(x) * 16'(y);
      2'd2:    return {13'd0, x > y, x == y, x < y};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string req_of(logic [1:0] op);
    case (op)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%0d a=%0d b=%0d got=%h exp=%h", req, sel, a, b, got, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [7:0] x, logic [7:0] y, logic [15:0] exp, string req);
    @(posedge clk);
    sel = op; a = x; b = y;
    @(negedge clk);
    check(req, res, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", res, 16'h0000);  // reset state, idle code

    foreach (TBL[i]) begin
      apply(TBL[i][33:32], TBL[i][31:24], TBL[i][23:16], TBL[i][15:0], "R6");
    end

    // R5: switch only the function code under fixed operands
    for (int op = 0; op < 4; op++) begin
      @(posedge clk);
      a = 8'd77; b = 8'd150; sel = 2'(op);
      @(negedge clk);
      check("R5", res, model(2'(op), 8'd77, 8'd150));
    end

    // strided sweep of operand pairs against reference arithmetic (R1..R4)
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y += 7) begin
        for (int op = 0; op < 4; op++) begin
          apply(2'(op), 8'(x), 8'(y), model(2'(op), 8'(x), 8'(y)), req_of(2'(op)));
        end
      end
      for (int op = 0; op < 4; op++) begin
        apply(2'(op), 8'(x), 8'd255, model(2'(op), 8'(x), 8'd255), req_of(2'(op)));
        apply(2'(op), 8'(x), 8'(x), model(2'(op), 8'(x), 8'(x)), req_of(2'(op)));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule